// File: doc/BRIEF.md
# Flash Write-Protection Front End

This block sits between a parallel flash-style bus (active-low chip select, output enable and write enable, plus address and data) and the internal command machinery of a flash array. It decides which bus write cycles count. A cycle counts only if the strobes stay in the write state long enough to rule out a glitch. It must not be an inhibited combination and must not fall inside a supply lockout. It must also not be a leftover strobe that was already low when the part came out of reset. Each cycle that counts produces a single-cycle accept pulse together with the address and data that the bus held last.

Accepted cycles go to a small command tracker. The tracker releases a program or erase request only after a three-cycle unlock sequence completes. Any wrong cycle, any reset byte, and any request that targets a hardware-protected sector returns the tracker to read mode. A reset line to the command decoder stays high while the supply is locked out.

All bus inputs are treated as already synchronous to `clk_i`. The glitch threshold is expressed as a minimum number of clock cycles.

Top module: `flash_wr_guard`

## Requirements
- R1: During and directly after reset, `wr_acc_o` and `req_vld_o` are 0, `rd_mode_o` is 1 and `cmd_rst_o` is 1.
- R2: Suppose the write state (`cs_ni`=0, `we_ni`=0, `oe_ni`=1, `lockout_i`=0) is sampled on at least MIN_PULSE consecutive clock edges, and the cycle is then ended by `we_ni` or `cs_ni` going high while `oe_ni` stays high. Then `wr_acc_o` is 1 for exactly one cycle, in the cycle after the edge that first sees the ended state. `wr_addr_o`/`wr_data_o` carry the bus values from the last edge on which the write state was sampled.
- R3: A write state held for fewer than MIN_PULSE edges gives no accept.
- R4: If `oe_ni` goes low while a write state is held, that cycle is abandoned and gives no accept, even if the strobes rise later.
- R5: A write state that is already present when reset is released gives no accept. Counting starts only after the write state has been seen absent on at least one edge.
- R6: While `lockout_i` is 1, no write is accepted, the tracker returns to read mode, and `cmd_rst_o` is 1 from the following cycle on. A write state that spans a lockout gives no accept. `cmd_rst_o` returns to 0 one cycle after lockout ends.
- R7: A program request is issued after four accepted cycles: (low 12 address bits 0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0xA0), and then any target. `req_vld_o` pulses one cycle after the fourth accept, with `req_erase_o`=0 and the target address and data.
- R8: An erase request is issued when the third unlock byte is 0x80 and the next accepted cycle carries data 0x30. `req_vld_o` then pulses with `req_erase_o`=1 and the target address.
- R9: An accepted cycle that does not match the next expected step returns the tracker to read mode (`rd_mode_o`=1), and no request is issued.
- R10: An accepted cycle with data 0xF0 returns the tracker to read mode from any state.
- R11: If the target's sector bit `protect_i[addr >> SECT_SHIFT]` is 1, the program or erase request is dropped and the tracker returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lockout_i | input | 1 | Supply below lockout level |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| protect_i | input | NSEC | Per-sector protect flags |
| wr_acc_o | output | 1 | One-cycle accept pulse |
| wr_addr_o | output | AW | Address of last accepted cycle |
| wr_data_o | output | DW | Data of last accepted cycle |
| req_vld_o | output | 1 | One-cycle program/erase request |
| req_erase_o | output | 1 | 1 = erase, 0 = program |
| req_addr_o | output | AW | Request target address |
| req_data_o | output | DW | Request data |
| rd_mode_o | output | 1 | Tracker is in read mode |
| cmd_rst_o | output | 1 | Reset to command decoder |

## Verification
The bench tests the glitch threshold at MIN_PULSE-1 and MIN_PULSE edges. A counter that is off by one would reject legal writes or accept glitches. It also holds the strobes low across reset release and across a lockout. A design that forgets the power-up or lockout rule would accept the stale rising edge there. Sequences are broken at each unlock step, with a reset byte and with a protected target. A tracker that does not fall back would later issue requests after only a partial unlock, or would program a protected sector.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG, ST_ERASE
  } seq_st_e;

  localparam logic [11:0] UNL_ADDR_A = 12'h555;
  localparam logic [11:0] UNL_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_ERCONF  = 8'h30;
  localparam logic [7:0]  OP_RESET   = 8'hF0;
endpackage

// File: rtl/fwg_strobe_qual.sv
module fwg_strobe_qual #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          cs_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          acc_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [CW-1:0] run_q;
  logic          blocked_q;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;
  logic          wr_cond, strobe_end, armed, acc_d;

  assign wr_cond    = !cs_ni && !we_ni && oe_ni && !lock_i;
  // cycle closed by WE/CS rising; OE low or lockout abandons it
  assign strobe_end = (cs_ni || we_ni) && oe_ni && !lock_i;
  assign armed      = run_q >= CW'(MIN_PULSE);
  assign acc_d      = strobe_end && armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      blocked_q   <= 1'b1;
      hold_addr_q <= '0;
      hold_data_q <= '0;
      acc_o       <= 1'b0;
      addr_o      <= '0;
      data_o      <= '0;
    end else begin
      acc_o <= acc_d;
      if (acc_d) begin
        addr_o <= hold_addr_q;
        data_o <= hold_data_q;
      end
      if (wr_cond) begin
        hold_addr_q <= addr_i;
        hold_data_q <= data_i;
      end
      if (lock_i)        blocked_q <= 1'b1;
      else if (!wr_cond) blocked_q <= 1'b0;
      if (lock_i || blocked_q || !wr_cond) run_q <= '0;
      else if (!armed)                     run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/fwg_sect_mask.sv
module fwg_sect_mask #(
  parameter int AW         = 16,
  parameter int SECT_SHIFT = 12,
  localparam int NSEC      = 2 ** (AW - SECT_SHIFT)
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [NSEC-1:0] protect_i,
  output logic            hit_o
);
  logic [AW-SECT_SHIFT-1:0] sect_idx;
  assign sect_idx = addr_i[AW-1:SECT_SHIFT];
  assign hit_o    = protect_i[sect_idx];
endmodule

// File: rtl/fwg_unlock_seq.sv
module fwg_unlock_seq
  import fwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          prot_hit_i,
  output logic          req_vld_o,
  output logic          req_erase_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o,
  output logic          rd_mode_o,
  output logic          cmd_rst_o
);
  seq_st_e    st_q, st_d;
  logic       fire, fire_erase;
  logic [11:0] a12;
  logic [7:0]  d8;

  assign a12 = 12'(addr_i);
  assign d8  = 8'(data_i);

  always_comb begin
    st_d       = ST_READ;
    fire       = 1'b0;
    fire_erase = 1'b0;
    if (d8 != OP_RESET) begin
      unique case (st_q)
        ST_READ: if (a12 == UNL_ADDR_A && d8 == KEY_A) st_d = ST_UNL1;
        ST_UNL1: if (a12 == UNL_ADDR_B && d8 == KEY_B) st_d = ST_UNL2;
        ST_UNL2: begin
          if (a12 == UNL_ADDR_A && d8 == OP_PROG)  st_d = ST_PROG;
          if (a12 == UNL_ADDR_A && d8 == OP_ERASE) st_d = ST_ERASE;
        end
        ST_PROG:  fire = !prot_hit_i;
        ST_ERASE: begin
          fire       = (d8 == OP_ERCONF) && !prot_hit_i;
          fire_erase = 1'b1;
        end
        default: st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_READ;
      req_vld_o   <= 1'b0;
      req_erase_o <= 1'b0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
      cmd_rst_o   <= 1'b1;
    end else begin
      cmd_rst_o <= lock_i;
      req_vld_o <= 1'b0;
      if (lock_i) begin
        st_q <= ST_READ;
      end else if (acc_i) begin
        st_q      <= st_d;
        req_vld_o <= fire;
        if (fire) begin
          req_erase_o <= fire_erase;
          req_addr_o  <= addr_i;
          req_data_o  <= data_i;
        end
      end
    end
  end

  assign rd_mode_o = (st_q == ST_READ);
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int MIN_PULSE  = 3,
  parameter int SECT_SHIFT = 12,
  localparam int NSEC      = 2 ** (AW - SECT_SHIFT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lockout_i,
  input  logic            cs_ni,
  input  logic            oe_ni,
  input  logic            we_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [NSEC-1:0] protect_i,
  output logic            wr_acc_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            req_vld_o,
  output logic            req_erase_o,
  output logic [AW-1:0]   req_addr_o,
  output logic [DW-1:0]   req_data_o,
  output logic            rd_mode_o,
  output logic            cmd_rst_o
);
  logic prot_hit;

  fwg_strobe_qual #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk_i, .rst_ni, .lock_i(lockout_i), .cs_ni, .oe_ni, .we_ni,
    .addr_i, .data_i, .acc_o(wr_acc_o), .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  fwg_sect_mask #(.AW(AW), .SECT_SHIFT(SECT_SHIFT)) u_mask (
    .addr_i(wr_addr_o), .protect_i, .hit_o(prot_hit)
  );

  fwg_unlock_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni, .lock_i(lockout_i), .acc_i(wr_acc_o),
    .addr_i(wr_addr_o), .data_i(wr_data_o), .prot_hit_i(prot_hit),
    .req_vld_o, .req_erase_o, .req_addr_o, .req_data_o, .rd_mode_o, .cmd_rst_o
  );
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
  parameter int AW         = 16,
  parameter int SECT_SHIFT = 12,
  localparam int NSEC      = 2 ** (AW - SECT_SHIFT)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lockout_i,
  input logic            cs_ni,
  input logic            oe_ni,
  input logic            we_ni,
  input logic [NSEC-1:0] protect_i,
  input logic            wr_acc_o,
  input logic [AW-1:0]   wr_addr_o,
  input logic            req_vld_o,
  input logic            rd_mode_o,
  input logic            cmd_rst_o
);
  logic prot_hit, wr_state;
  assign prot_hit = protect_i[wr_addr_o[AW-1:SECT_SHIFT]];
  assign wr_state = !cs_ni && !we_ni && oe_ni;

  a_r2_acc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_o |=> !wr_acc_o);
  a_r2_acc_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_o |-> $past(wr_state, 2));
  a_r4_oe_low_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |=> !wr_acc_o);
  a_r6_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (!wr_acc_o && cmd_rst_o && rd_mode_o));
  a_r7_req_follows_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o |-> $past(wr_acc_o));
  a_r11_no_prot_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o |-> !$past(prot_hit));
endmodule

bind flash_wr_guard fwg_checker #(.AW(AW), .SECT_SHIFT(SECT_SHIFT)) u_chk (.*);

// File: tb/flash_wr_guard_tb_top.sv
module flash_wr_guard_tb_top;
  localparam int AW = 16, DW = 8, MINP = 3, SH = 12;
  localparam int NSEC = 2 ** (AW - SH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock = 1'b0, cs_n = 1'b0, oe_n = 1'b1, we_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [NSEC-1:0] prot = '0;
  logic wr_acc, req_vld, req_erase, rd_mode, cmd_rst;
  logic [AW-1:0] wr_addr, req_addr;
  logic [DW-1:0] wr_data, req_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_wr_guard #(.AW(AW), .DW(DW), .MIN_PULSE(MINP), .SECT_SHIFT(SH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lock), .cs_ni(cs_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .data_i(data), .protect_i(prot),
    .wr_acc_o(wr_acc), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .req_vld_o(req_vld), .req_erase_o(req_erase), .req_addr_o(req_addr),
    .req_data_o(req_data), .rd_mode_o(rd_mode), .cmd_rst_o(cmd_rst)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int run = 0, stage = 0;
  bit blk = 1;
  logic [AW-1:0] h_a = '0, m_wa = '0, m_ra = '0;
  logic [DW-1:0] h_d = '0, m_wd = '0, m_rd = '0;
  bit m_acc = 0, m_req = 0, m_er = 0, m_crst = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      run = 0; stage = 0; blk = 1; h_a = '0; h_d = '0; m_wa = '0; m_wd = '0;
      m_ra = '0; m_rd = '0; m_acc = 0; m_req = 0; m_er = 0; m_crst = 1;
    end else begin
      bit cond, ended, p_acc, pr, nacc;
      logic [AW-1:0] pa; logic [DW-1:0] pd;
      cond  = !cs_n && !we_n && oe_n && !lock;
      ended = (cs_n || we_n) && oe_n && !lock;
      p_acc = m_acc; pa = m_wa; pd = m_wd;
      pr = prot[pa >> SH];
      m_req = 0; m_crst = lock;
      if (lock) stage = 0;
      else if (p_acc) begin
        if (pd == 8'hF0) stage = 0;
        else case (stage)
          0: stage = (pa[11:0] == 12'h555 && pd == 8'hAA) ? 1 : 0;
          1: stage = (pa[11:0] == 12'h2AA && pd == 8'h55) ? 2 : 0;
          2: stage = (pa[11:0] != 12'h555) ? 0 : (pd == 8'hA0) ? 3 : (pd == 8'h80) ? 4 : 0;
          3: begin if (!pr) begin m_req = 1; m_er = 0; m_ra = pa; m_rd = pd; end stage = 0; end
          default: begin
            if (!pr && pd == 8'h30) begin m_req = 1; m_er = 1; m_ra = pa; m_rd = pd; end
            stage = 0;
          end
        endcase
      end
      nacc = ended && run >= MINP;
      m_acc = nacc;
      if (nacc) begin m_wa = h_a; m_wd = h_d; end
      if (cond) begin h_a = addr; h_d = data; end
      if (lock || blk || !cond) run = 0; else run = run + 1;
      if (lock) blk = 1; else if (!cond) blk = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(wr_acc == m_acc && wr_addr == m_wa && wr_data == m_wd, "R2 model wr", wr_acc, m_acc);
    chk(req_vld == m_req && (!m_req || (req_erase == m_er && req_addr == m_ra && req_data == m_rd)),
        "R7 model req", req_vld, m_req);
    chk(rd_mode == (stage == 0), "R9 model rd_mode", rd_mode, stage == 0);
    chk(cmd_rst == m_crst, "R6 model cmd_rst", cmd_rst, m_crst);
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n,
                        output bit acc, output bit req);
    @(negedge clk); addr = a; data = d; cs_n = 0; we_n = 0;
    repeat (n) @(negedge clk);
    we_n = 1; cs_n = 1;
    @(negedge clk); acc = wr_acc;
    @(negedge clk); req = req_vld;
  endtask

  task automatic unlock(input logic [7:0] op);
    bit a, r;
    bus_wr(16'h0555, 8'hAA, MINP, a, r);
    bus_wr(16'h02AA, 8'h55, MINP, a, r);
    bus_wr(16'h0555, op, MINP, a, r);
  endtask

  initial begin
    bit a, r;
    // R5: strobes low across reset release
    repeat (3) @(negedge clk);
    chk(wr_acc == 0 && req_vld == 0, "R1 reset pulses", wr_acc, 0);
    chk(rd_mode == 1 && cmd_rst == 1, "R1 reset modes", {rd_mode, cmd_rst}, 2'b11);
    rst_n = 1;
    repeat (5) @(negedge clk);
    we_n = 1; cs_n = 1;
    @(negedge clk);
    chk(wr_acc == 0, "R5 power-up edge ignored", wr_acc, 0);
    chk(cmd_rst == 0, "R6 cmd_rst low in normal run", cmd_rst, 0);
    // R3 / R2
    bus_wr(16'h1234, 8'h11, MINP - 1, a, r);
    chk(a == 0, "R3 short pulse rejected", a, 0);
    bus_wr(16'h4321, 8'h22, MINP, a, r);
    chk(a == 1, "R2 min pulse accepted", a, 1);
    chk(wr_addr == 16'h4321 && wr_data == 8'h22, "R2 captured addr/data", {wr_addr, wr_data}, 24'h432122);
    // R2: ended by CS only
    @(negedge clk); addr = 16'h0777; data = 8'h33; cs_n = 0; we_n = 0;
    repeat (MINP + 2) @(negedge clk);
    cs_n = 1;
    @(negedge clk); chk(wr_acc == 1, "R2 cs rise accepted", wr_acc, 1);
    @(negedge clk); chk(wr_acc == 0, "R2 pulse is one cycle", wr_acc, 0);
    we_n = 1;
    // R4
    @(negedge clk); cs_n = 0; we_n = 0;
    repeat (MINP + 1) @(negedge clk);
    oe_n = 0; @(negedge clk);
    oe_n = 1; cs_n = 1; we_n = 1;
    @(negedge clk); chk(wr_acc == 0, "R4 oe low abandons", wr_acc, 0);
    // R7
    unlock(8'hA0);
    chk(rd_mode == 0, "R7 armed for program", rd_mode, 0);
    bus_wr(16'h1234, 8'h5A, MINP, a, r);
    chk(r == 1 && req_erase == 0 && req_addr == 16'h1234 && req_data == 8'h5A,
        "R7 program request", {r, req_erase, req_addr}, {2'b10, 16'h1234});
    chk(rd_mode == 1, "R7 back to read", rd_mode, 1);
    // R8
    unlock(8'h80);
    bus_wr(16'h3000, 8'h30, MINP, a, r);
    chk(r == 1 && req_erase == 1 && req_addr == 16'h3000, "R8 erase request",
        {r, req_erase, req_addr}, {2'b11, 16'h3000});
    // R9
    bus_wr(16'h0555, 8'hAA, MINP, a, r);
    chk(rd_mode == 0, "R9 first step taken", rd_mode, 0);
    bus_wr(16'h0123, 8'h55, MINP, a, r);
    chk(rd_mode == 1, "R9 wrong address falls back", rd_mode, 1);
    bus_wr(16'h0555, 8'hA0, MINP, a, r);
    bus_wr(16'h1000, 8'h77, MINP, a, r);
    chk(r == 0, "R9 no request after broken unlock", r, 0);
    // R10
    bus_wr(16'h0555, 8'hAA, MINP, a, r);
    bus_wr(16'h02AA, 8'h55, MINP, a, r);
    chk(rd_mode == 0, "R10 mid sequence", rd_mode, 0);
    bus_wr(16'h0000, 8'hF0, MINP, a, r);
    chk(rd_mode == 1, "R10 reset byte", rd_mode, 1);
    // R11
    prot = 16'h0020;
    unlock(8'hA0);
    bus_wr(16'h5010, 8'h99, MINP, a, r);
    chk(r == 0 && rd_mode == 1, "R11 protected program dropped", {r, rd_mode}, 2'b01);
    unlock(8'h80);
    bus_wr(16'h5000, 8'h30, MINP, a, r);
    chk(r == 0, "R11 protected erase dropped", r, 0);
    unlock(8'hA0);
    bus_wr(16'h6010, 8'h99, MINP, a, r);
    chk(r == 1, "R11 unprotected sector passes", r, 1);
    prot = '0;
    // R6
    bus_wr(16'h0555, 8'hAA, MINP, a, r);
    @(negedge clk); addr = 16'h02AA; data = 8'h55; cs_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    lock = 1;
    repeat (2) @(negedge clk);
    chk(cmd_rst == 1 && rd_mode == 1, "R6 lockout resets tracker", {cmd_rst, rd_mode}, 2'b11);
    lock = 0;
    repeat (4) @(negedge clk);
    chk(cmd_rst == 0, "R6 cmd_rst released", cmd_rst, 0);
    we_n = 1; cs_n = 1;
    @(negedge clk); chk(wr_acc == 0, "R6 write spanning lockout ignored", wr_acc, 0);
    @(negedge clk); lock = 1; cs_n = 0; we_n = 0;
    repeat (MINP + 2) @(negedge clk);
    cs_n = 1; we_n = 1;
    @(negedge clk); chk(wr_acc == 0, "R6 write during lockout ignored", wr_acc, 0);
    lock = 0;
    bus_wr(16'h0abc, 8'h44, MINP, a, r);
    chk(a == 1, "R6 writes resume after lockout", a, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule